// File: doc/BRIEF.md
# Image Rotation Engine Register Block

This block is the software-visible register file for a memory-to-memory image rotation engine. Software programs an interrupt enable, a pixel format, a flip mode and a rotation angle. It also programs source and destination geometry: buffer sizes, crop origins, the source crop extent, and one address per image plane on each side. It then sets a start bit. The block passes the job to the engine as a level request. The request drops on its own once the engine acknowledges it.

When the engine reports a finished job or an illegal setting, the block records a result code and sets a pending flag. An interrupt is raised whenever that flag is set and interrupts are enabled. Software acknowledges the interrupt by writing one to the flag. A start request is refused in two cases: while the block is suspended, and when the requested format is not one of the two legal ones. A release register zeroes all plane addresses of one side in a single write.

The bus is a plain single-cycle word-addressed interface. Writes take effect at the clock edge and reads are combinational.

Top module: `rot_csr`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `eng_start` is low.
- R2: Word 0 bit 0 is the interrupt enable. It is read/write, and all other bits of word 0 read zero.
- R3: Word 1 stores format in bits [1:0], flip in bits [3:2] and rotation in bits [5:4]. All 64 combinations read back unchanged. A write without bit 8 never starts a job.
- R4: Geometry words 4..12 are full 32-bit read/write registers, in this order: source size, source crop origin, source crop extent, destination size, destination crop origin, source plane 0 and plane 1 addresses, destination plane 0 and plane 1 addresses. Size words carry height in [31:16] and width in [15:0], and origin words carry Y in [31:16] and X in [15:0].
- R5: Writing word 1 with bit 8 set and a legal format (01 = two-plane YCbCr 4:2:0, 10 = 32-bit RGB) while not suspended sets bit 8 and drives `eng_start` high from the next cycle. Both clear in the cycle after `eng_ack` is sampled high. The other fields are kept.
- R6: A start request while `suspended` is high does not raise `eng_start`. It instead sets status bit 5, which is cleared by writing one to it.
- R7: A pulse on `eng_done` sets the status code in bits [1:0] to 01 and sets pending bit 4. A pulse on `eng_illegal` sets the code to 10 and sets pending.
- R8: Writing one to status bit 4 clears pending. Writing zero to status bits leaves them unchanged, and the result code is never changed by a write.
- R9: `irq` is high exactly when pending and the interrupt enable are both set, and it is low in the cycle after the pending flag is cleared.
- R10: Writing word 3 with bit 0 set zeroes both source plane addresses, and with bit 1 set zeroes both destination plane addresses. The other geometry words are unaffected, and word 3 reads zero.
- R11: A start request with format 00 or 11 does not raise `eng_start`. It sets the status code to 10 and sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| suspended | input | 1 | High while the engine is powered down |
| eng_start | output | 1 | Job request to the engine |
| eng_ack | input | 1 | Engine has taken the job |
| eng_done | input | 1 | Job completed pulse |
| eng_illegal | input | 1 | Illegal setting pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a status word that holds the suspend-refusal flag beside a stale result code from an earlier job. It is only there if a job has completed and been acknowledged, and then a start is attempted while suspended. The bench runs a full job cycle first: start, acknowledge, completion, clear. It then raises `suspended` and retries the start, and checks that only bit 5 is added and that the old code survives. The rejection paths for both illegal format values are driven in the same way, after interrupts have been disabled and re-enabled.

// File: rtl/rot_csr_pkg.sv
package rot_csr_pkg;
   localparam int A_CFG  = 0;
   localparam int A_CTRL = 1;
   localparam int A_STAT = 2;
   localparam int A_REL  = 3;
   localparam int A_GEO  = 4;
   localparam int N_GEO_PLAIN = 5;

   localparam int B_START = 8;
   localparam int B_PEND  = 4;
   localparam int B_SERR  = 5;

   localparam logic [1:0] FMT_YUV2P = 2'b01;
   localparam logic [1:0] FMT_RGB32 = 2'b10;
   localparam logic [1:0] RES_DONE  = 2'b01;
   localparam logic [1:0] RES_ILL   = 2'b10;
endpackage

// File: rtl/rot_csr_regbank.sv
module rot_csr_regbank
   import rot_csr_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 5,
   parameter int NPLANE = 2,
   localparam int NREG  = N_GEO_PLAIN + 2 * NPLANE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [AW-1:0]            idx,
   input  logic [DW-1:0]            wdata,
   input  logic                     clr_src,
   input  logic                     clr_dst,
   output logic [NREG-1:0][DW-1:0]  q
);
   localparam int SRC_LO = N_GEO_PLAIN;
   localparam int DST_LO = N_GEO_PLAIN + NPLANE;

   if (NPLANE < 1 || NPLANE > 3) begin : g_bad_nplane
      $error("rot_csr_regbank: NPLANE must be 1..3");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic clr;
      if (g >= DST_LO) begin : g_dst
         assign clr = clr_dst;
      end else if (g >= SRC_LO) begin : g_src
         assign clr = clr_src;
      end else begin : g_plain
         assign clr = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q[g] <= '0;
         else if (clr)                    q[g] <= '0;
         else if (wr && idx == AW'(g))    q[g] <= wdata;
      end
   end

   AST_REL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      clr_src |=> q[SRC_LO] == '0); // R10
   AST_REL_DST: assert property (@(posedge clk) disable iff (!rst_n)
      clr_dst |=> q[DST_LO] == '0); // R10
endmodule

// File: rtl/rot_csr_ctrl.sv
module rot_csr_ctrl
   import rot_csr_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cfg,
   input  logic          wr_ctrl,
   input  logic [DW-1:0] wdata,
   input  logic          suspended,
   input  logic          eng_ack,
   output logic          irq_en,
   output logic          start_q,
   output logic [DW-1:0] cfg_word,
   output logic [DW-1:0] ctrl_word,
   output logic          susp_reject,
   output logic          fmt_reject
);
   logic [1:0] fmt_q, flip_q, rot_q;
   logic       start_req, fmt_ok, launch;

   assign start_req   = wr_ctrl && wdata[B_START];
   assign fmt_ok      = (wdata[1:0] == FMT_YUV2P) || (wdata[1:0] == FMT_RGB32);
   assign susp_reject = start_req && suspended;
   assign fmt_reject  = start_req && !suspended && !fmt_ok;
   assign launch      = start_req && !suspended && fmt_ok && !start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en  <= 1'b0;
         fmt_q   <= '0;
         flip_q  <= '0;
         rot_q   <= '0;
         start_q <= 1'b0;
      end else begin
         if (wr_cfg) irq_en <= wdata[0];
         if (wr_ctrl) begin
            fmt_q  <= wdata[1:0];
            flip_q <= wdata[3:2];
            rot_q  <= wdata[5:4];
         end
         if (launch)       start_q <= 1'b1;
         else if (eng_ack) start_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_word        = '0;
      cfg_word[0]     = irq_en;
      ctrl_word       = '0;
      ctrl_word[1:0]  = fmt_q;
      ctrl_word[3:2]  = flip_q;
      ctrl_word[5:4]  = rot_q;
      ctrl_word[B_START] = start_q;
   end

   AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && eng_ack) |=> !start_q); // R5
   AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && !start_q) |=> !start_q); // R6
endmodule

// File: rtl/rot_csr_status.sv
module rot_csr_status
   import rot_csr_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eng_done,
   input  logic          eng_illegal,
   input  logic          fmt_reject,
   input  logic          susp_reject,
   input  logic          wr_stat,
   input  logic [DW-1:0] wdata,
   input  logic          irq_en,
   output logic [DW-1:0] stat_word,
   output logic          irq
);
   logic [1:0] code_q;
   logic       pend_q, serr_q, bad;

   assign bad = eng_illegal || fmt_reject;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         pend_q <= 1'b0;
         serr_q <= 1'b0;
      end else begin
         if (eng_done)  code_q <= RES_DONE;
         else if (bad)  code_q <= RES_ILL;

         if (eng_done || bad)                  pend_q <= 1'b1;
         else if (wr_stat && wdata[B_PEND])    pend_q <= 1'b0;

         if (susp_reject)                      serr_q <= 1'b1;
         else if (wr_stat && wdata[B_SERR])    serr_q <= 1'b0;
      end
   end

   always_comb begin
      stat_word         = '0;
      stat_word[1:0]    = code_q;
      stat_word[B_PEND] = pend_q;
      stat_word[B_SERR] = serr_q;
   end

   assign irq = pend_q && irq_en;

   AST_DONE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (pend_q && code_q == RES_DONE)); // R7
   AST_W1C_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[B_PEND] && !eng_done && !bad) |=> !pend_q); // R8
   AST_CODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_done && !bad) |=> $stable(code_q)); // R8
endmodule

// File: rtl/rot_csr.sv
module rot_csr
   import rot_csr_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 5,
   parameter int NPLANE = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          suspended,
   output logic          eng_start,
   input  logic          eng_ack,
   input  logic          eng_done,
   input  logic          eng_illegal,
   output logic          irq
);
   localparam int NREG = N_GEO_PLAIN + 2 * NPLANE;

   if (DW < 32) begin : g_bad_dw
      $error("rot_csr: DW must be at least 32");
   end
   if (A_GEO + NREG > (1 << AW)) begin : g_bad_aw
      $error("rot_csr: AW too narrow for the register map");
   end

   logic                    wr_cfg, wr_ctrl, wr_stat, wr_rel, wr_geo;
   logic [AW-1:0]           geo_idx;
   logic [NREG-1:0][DW-1:0] geo_q;
   logic [DW-1:0]           cfg_word, ctrl_word, stat_word;
   logic                    irq_en, susp_reject, fmt_reject;

   assign wr_cfg  = bus_wr && bus_addr == AW'(A_CFG);
   assign wr_ctrl = bus_wr && bus_addr == AW'(A_CTRL);
   assign wr_stat = bus_wr && bus_addr == AW'(A_STAT);
   assign wr_rel  = bus_wr && bus_addr == AW'(A_REL);
   assign wr_geo  = bus_wr && bus_addr >= AW'(A_GEO);
   assign geo_idx = bus_addr - AW'(A_GEO);

   rot_csr_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_ctrl(wr_ctrl),
      .wdata(bus_wdata), .suspended(suspended), .eng_ack(eng_ack),
      .irq_en(irq_en), .start_q(eng_start), .cfg_word(cfg_word),
      .ctrl_word(ctrl_word), .susp_reject(susp_reject), .fmt_reject(fmt_reject)
   );

   rot_csr_status #(.DW(DW)) u_stat (
      .clk(clk), .rst_n(rst_n), .eng_done(eng_done), .eng_illegal(eng_illegal),
      .fmt_reject(fmt_reject), .susp_reject(susp_reject), .wr_stat(wr_stat),
      .wdata(bus_wdata), .irq_en(irq_en), .stat_word(stat_word), .irq(irq)
   );

   rot_csr_regbank #(.DW(DW), .AW(AW), .NPLANE(NPLANE)) u_geo (
      .clk(clk), .rst_n(rst_n), .wr(wr_geo), .idx(geo_idx), .wdata(bus_wdata),
      .clr_src(wr_rel && bus_wdata[0]), .clr_dst(wr_rel && bus_wdata[1]),
      .q(geo_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(A_CFG))                        bus_rdata = cfg_word;
      else if (bus_addr == AW'(A_CTRL))                  bus_rdata = ctrl_word;
      else if (bus_addr == AW'(A_STAT))                  bus_rdata = stat_word;
      else if (bus_addr >= AW'(A_GEO) && geo_idx < AW'(NREG)) bus_rdata = geo_q[geo_idx];
   end

   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[B_PEND] && !eng_done && !eng_illegal && !wr_ctrl) |=> !irq); // R9
endmodule

// File: tb/rot_csr_bench.sv
module rot_csr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        suspended = 1'b0;
   logic        eng_start, irq;
   logic        eng_ack = 1'b0, eng_done = 1'b0, eng_illegal = 1'b0;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   rot_csr u_rot_csr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .suspended(suspended),
      .eng_start(eng_start), .eng_ack(eng_ack), .eng_done(eng_done),
      .eng_illegal(eng_illegal), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 5'(a);
      #1 d = bus_rdata;
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic pulse_ill();
      @(negedge clk); eng_illegal = 1'b1; @(negedge clk); eng_illegal = 1'b0;
   endtask

   function automatic logic [31:0] geo_pat(input int i);
      return {16'(i * 37 + 5), 16'(i * 101 + 3)};
   endfunction

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 13; a++) begin rd(a, v); chk("R1", v, 0); end
      chk("R1 irq", 32'(irq), 0);
      chk("R1 start", 32'(eng_start), 0);

      // R2 interrupt enable
      wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2", v, 1);
      wr(0, 32'h0000_0000); rd(0, v); chk("R2", v, 0);

      // R3 full sweep of format, flip and rotation
      for (int f = 0; f < 4; f++)
         for (int fl = 0; fl < 4; fl++)
            for (int r = 0; r < 4; r++) begin
               logic [31:0] e;
               e = 32'((r << 4) | (fl << 2) | f);
               wr(1, e); rd(1, v); chk("R3", v, e);
               chk("R3 no start", 32'(eng_start), 0);
            end

      // R4 geometry registers
      for (int i = 0; i < 9; i++) wr(4 + i, geo_pat(i));
      for (int i = 0; i < 9; i++) begin rd(4 + i, v); chk("R4", v, geo_pat(i)); end
      rd(7, v); chk("R4 height", 32'(v[31:16]), 32'(16'(3 * 37 + 5)));
      rd(7, v); chk("R4 width", 32'(v[15:0]), 32'(16'(3 * 101 + 3)));

      // R10 release
      wr(3, 32'h1);
      for (int i = 0; i < 9; i++) begin
         rd(4 + i, v); chk("R10 src", v, (i == 5 || i == 6) ? 32'h0 : geo_pat(i));
      end
      rd(3, v); chk("R10 reads zero", v, 0);
      wr(3, 32'h2);
      for (int i = 0; i < 9; i++) begin
         rd(4 + i, v); chk("R10 dst", v, (i >= 5) ? 32'h0 : geo_pat(i));
      end

      // R5 start and self clear
      wr(0, 1);
      wr(1, 32'h0000_0111);
      chk("R5 start", 32'(eng_start), 1);
      rd(1, v); chk("R5 bit8", v, 32'h111);
      repeat (3) @(negedge clk);
      chk("R5 held", 32'(eng_start), 1);
      eng_ack = 1'b1; @(negedge clk); eng_ack = 1'b0;
      chk("R5 cleared", 32'(eng_start), 0);
      rd(1, v); chk("R5 fields kept", v, 32'h011);

      // R7 and R9 completion
      pulse_done();
      rd(2, v); chk("R7 done", v, 32'h11);
      chk("R9 irq", 32'(irq), 1);
      wr(2, 32'h0); rd(2, v); chk("R8 zero write", v, 32'h11);
      wr(2, 32'h10); rd(2, v); chk("R8 w1c", v, 32'h01);
      chk("R9 irq low", 32'(irq), 0);
      pulse_ill();
      rd(2, v); chk("R7 illegal", v, 32'h12);
      chk("R9 irq", 32'(irq), 1);
      wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R8 code kept", v, 32'h02);
      wr(0, 0);
      pulse_done();
      chk("R9 masked", 32'(irq), 0);
      rd(2, v); chk("R7 done", v, 32'h11);
      wr(2, 32'h10);
      wr(0, 1);

      // R6 suspended start
      suspended = 1'b1;
      wr(1, 32'h0000_0102);
      chk("R6 no start", 32'(eng_start), 0);
      rd(2, v); chk("R6 flag", v, 32'h21);
      wr(2, 32'h20); rd(2, v); chk("R6 clear", v, 32'h01);
      suspended = 1'b0;

      // R11 illegal format start
      for (int f = 0; f < 4; f += 3) begin
         wr(1, 32'h100 | 32'(f));
         chk("R11 no start", 32'(eng_start), 0);
         rd(2, v); chk("R11 status", v, 32'h12);
         chk("R11 irq", 32'(irq), 1);
         wr(2, 32'h10);
         wr(2, 32'h0);
      end
      wr(1, 32'h0000_0102);
      chk("R5 rgb start", 32'(eng_start), 1);
      eng_ack = 1'b1; @(negedge clk); eng_ack = 1'b0;
      chk("R5 rgb clear", 32'(eng_start), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule